// File: doc/BRIEF.md
# Byte Opcode Decoder

This block sits between the fetch stage and the execution sequencer of a small accumulator-based processor. Each time the fetch stage strobes a new opcode byte, the decoder works out what kind of instruction the byte is. It produces a micro-operation descriptor. The descriptor gives the operation class, the destination and source register slots, the register-pair index, a function code, the number of operand bytes still to fetch, the addressing mode, a timing class and, for restarts, the target vector. The descriptor appears on the outputs one clock after the strobe. It stays there until the next strobe, so the sequencer can read it for as long as the instruction runs.

Register slots are numbered 0 to 7. Slot 7 is the accumulator, and slot 6 is not a register: it is the byte in memory that the HL pair points at. Any operation that names slot 6 is moved up one timing class. The byte that introduces the second (prefixed) table is only flagged. Any byte outside the supported set is reported as illegal and decodes as a no-op.

Top module: `byte_op_decoder`

## Requirements
- R1: While `rst_n` is low, every output is 0. After each clock edge at which `op_valid_i` is high, `desc_valid_o` is 1 and the descriptor belongs to the opcode sampled at that edge. After an edge at which `op_valid_i` is low, `desc_valid_o` is 0.
- R2: With the default `HOLD_DESC`=1, an edge without a strobe leaves every descriptor output unchanged.
- R3: Opcodes 0x40–0x7F other than 0x76 decode as class 1 (byte load), with `dst_o`=bits 5:3 and `src_o`=bits 2:0. If either slot is 6, the mode is 2 (HL-indirect) and the timing is 1. Otherwise the mode is 1 (register) and the timing is 0.
- R4: Opcodes 0x80–0xBF decode as class 3 (ALU), with `fn_o`=bits 5:3 (0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 and, 5 xor, 6 or, 7 compare), `dst_o`=7 and `src_o`=bits 2:0. Mode and timing follow the slot-6 rule of R3.
- R5: Opcodes with bits 7:6=11 and bits 2:0=110 decode as class 3, with `fn_o`=bits 5:3, `dst_o`=7, one immediate byte, mode 3 (immediate) and timing 1.
- R6: With bits 7:6=00, a low field of 110 gives class 1, `dst_o`=bits 5:3, one immediate byte, mode 3, and timing 1 (2 when the slot is 6). A low field of 100 or 101 gives class 4 (increment/decrement), `dst_o`=bits 5:3 and `fn_o`=bit 0 (0 increment, 1 decrement); mode and timing follow the slot-6 rule of R3.
- R7: In the 00 quadrant, `pair_o`=bits 5:4 (0 BC, 1 DE, 2 HL, 3 SP). Low nibble 0001 gives class 2 with two immediate bytes, mode 3 and timing 2. Low field 011 gives class 4 with `fn_o`=bit 3, mode 1 and timing 1. Low nibble 1001 gives class 12 (16-bit add), mode 1 and timing 1.
- R8: Opcodes 0xC1/0xD1/0xE1/0xF1 decode as class 10 (pop) and 0xC5/0xD5/0xE5/0xF5 as class 9 (push), with `pair_o`=bits 5:4, mode 7 (stack) and timing 2. `pair_af_o` is 1 exactly when the pair index is 3, which here means the accumulator-and-flags pair.
- R9: Opcodes with bits 7:6=11 and bits 2:0=111 decode as class 8 (restart), with `rst_vec_o`=bits 5:3 times 8, mode 7 and timing 2.
- R10: 0xE0 (store accumulator) and 0xF0 (load accumulator) decode as class 1 with one immediate byte, mode 4 (0xFF00 plus immediate) and timing 2. 0xE2 and 0xF2 decode the same way but with no immediate byte, mode 5 (0xFF00 plus C) and timing 1. The stores have `src_o`=7 and the loads `dst_o`=7.
- R11: 0x18, 0x20, 0x28, 0x30 and 0x38 decode as class 5 with one immediate byte, mode 6 (relative) and timing 2. 0xC3 is class 5 and 0xCD is class 6 (call), each with two immediate bytes, mode 3 and timing 2. 0xC9 is class 7 (return) with mode 7 and timing 2.
- R12: 0x00 decodes as class 0 with every field 0. 0x76, 0x10 and 0xCB decode as class 11 (control) with `fn_o` 1 (halt), 2 (stop) and 3 (prefix) respectively. `prefix_o` is 1 only for 0xCB.
- R13: Every other opcode sets `illegal_o` to 1 and leaves all other descriptor fields 0. `illegal_o` is 0 for every opcode in R3–R12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Strobe: `opcode_i` holds a fresh byte |
| opcode_i | input | 8 | Fetched opcode byte |
| desc_valid_o | output | 1 | Descriptor was loaded at the last edge |
| op_class_o | output | 4 | Operation class code |
| dst_o | output | 3 | Destination register slot |
| src_o | output | 3 | Source register slot |
| pair_o | output | 2 | Register-pair index |
| fn_o | output | 3 | Function code within the class |
| imm_cnt_o | output | 2 | Operand bytes to fetch (0, 1 or 2) |
| addr_mode_o | output | 3 | Addressing mode code |
| timing_o | output | 2 | Timing class (0 short, 1 middle, 2 long) |
| rst_vec_o | output | 8 | Restart target vector |
| prefix_o | output | 1 | Opcode introduces the prefixed table |
| pair_af_o | output | 1 | Pair index 3 means accumulator-and-flags |
| illegal_o | output | 1 | Opcode not supported |

## Verification
The hardest behaviour to reach from the ports is retention: the hold rule only shows in a cycle with no strobe that follows a known descriptor. The bench therefore ends its full sweep with deliberate gaps after a non-trivial opcode and checks that every field stays put while the valid flag drops. The sweep runs all 256 byte values in back-to-back strobes. This puts the slot-6 overlap of destination and source (the halt byte inside the load block) and both stack-pair meanings side by side in consecutive cycles, so any leftover state from the previous opcode would show.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

   typedef enum logic [3:0] {
      CL_NOP    = 4'd0,
      CL_LD8    = 4'd1,
      CL_LD16   = 4'd2,
      CL_ALU    = 4'd3,
      CL_INCDEC = 4'd4,
      CL_JUMP   = 4'd5,
      CL_CALL   = 4'd6,
      CL_RET    = 4'd7,
      CL_RST    = 4'd8,
      CL_PUSH   = 4'd9,
      CL_POP    = 4'd10,
      CL_CTRL   = 4'd11,
      CL_ADD16  = 4'd12
   } op_class_e;

   typedef enum logic [2:0] {
      AM_NONE     = 3'd0,
      AM_REG      = 3'd1,
      AM_HLIND    = 3'd2,
      AM_IMM      = 3'd3,
      AM_HIGH_IMM = 3'd4,
      AM_HIGH_C   = 3'd5,
      AM_REL      = 3'd6,
      AM_STACK    = 3'd7
   } addr_mode_e;

   typedef enum logic [1:0] {
      TM_SHORT = 2'd0,
      TM_MID   = 2'd1,
      TM_LONG  = 2'd2,
      TM_RSVD  = 2'd3
   } timing_e;

   typedef struct packed {
      op_class_e  cls;
      logic [2:0] dst;
      logic [2:0] src;
      logic [1:0] pair;
      logic [2:0] fn;
      logic [1:0] imm;
      addr_mode_e mode;
      timing_e    tim;
      logic [7:0] vec;
      logic       prefix;
      logic       pair_af;
   } uop_t;

   localparam logic [2:0] SLOT_MEM = 3'd6;
   localparam logic [2:0] SLOT_ACC = 3'd7;

   function automatic uop_t uop_blank();
      uop_t u;
      u.cls     = CL_NOP;
      u.dst     = '0;
      u.src     = '0;
      u.pair    = '0;
      u.fn      = '0;
      u.imm     = '0;
      u.mode    = AM_NONE;
      u.tim     = TM_SHORT;
      u.vec     = '0;
      u.prefix  = 1'b0;
      u.pair_af = 1'b0;
      return u;
   endfunction

   // Raise a timing class by one step when the memory slot is involved.
   function automatic timing_e tim_bump(timing_e base, logic mem);
      timing_e r;
      r = base;
      if (mem) begin
         case (base)
            TM_SHORT: r = TM_MID;
            default:  r = TM_LONG;
         endcase
      end
      return r;
   endfunction

endpackage

// File: rtl/opdec_q01.sv
module opdec_q01
   import opdec_pkg::*;
(
   input  logic [7:0] op_i,
   output uop_t       uop_o,
   output logic       hit_o
);

   logic [1:0] quad;
   logic [2:0] ysel;
   logic [2:0] zsel;
   logic       mem_y;
   logic       mem_any;

   assign quad    = op_i[7:6];
   assign ysel    = op_i[5:3];
   assign zsel    = op_i[2:0];
   assign mem_y   = (ysel == SLOT_MEM);
   assign mem_any = mem_y || (zsel == SLOT_MEM);

   always_comb begin
      uop_o = uop_blank();
      hit_o = 1'b1;
      if (quad == 2'b01) begin
         if (op_i == 8'h76) begin
            uop_o.cls = CL_CTRL;
            uop_o.fn  = 3'd1;
         end else begin
            uop_o.cls = CL_LD8;
            uop_o.dst = ysel;
            uop_o.src = zsel;
            if (mem_any) uop_o.mode = AM_HLIND;
            else         uop_o.mode = AM_REG;
            uop_o.tim = tim_bump(TM_SHORT, mem_any);
         end
      end else if (quad == 2'b00) begin
         case (zsel)
            3'd0: begin
               if (op_i == 8'h00) begin
                  uop_o.cls = CL_NOP;
               end else if (op_i == 8'h10) begin
                  uop_o.cls = CL_CTRL;
                  uop_o.fn  = 3'd2;
               end else if (op_i[5] || (op_i[4:3] == 2'b11)) begin
                  uop_o.cls  = CL_JUMP;
                  uop_o.imm  = 2'd1;
                  uop_o.mode = AM_REL;
                  uop_o.tim  = TM_LONG;
               end else begin
                  hit_o = 1'b0;
               end
            end
            3'd1: begin
               uop_o.pair = op_i[5:4];
               if (!op_i[3]) begin
                  uop_o.cls  = CL_LD16;
                  uop_o.imm  = 2'd2;
                  uop_o.mode = AM_IMM;
                  uop_o.tim  = TM_LONG;
               end else begin
                  uop_o.cls  = CL_ADD16;
                  uop_o.mode = AM_REG;
                  uop_o.tim  = TM_MID;
               end
            end
            3'd3: begin
               uop_o.cls  = CL_INCDEC;
               uop_o.pair = op_i[5:4];
               uop_o.fn   = {2'b00, op_i[3]};
               uop_o.mode = AM_REG;
               uop_o.tim  = TM_MID;
            end
            3'd4, 3'd5: begin
               uop_o.cls = CL_INCDEC;
               uop_o.dst = ysel;
               uop_o.fn  = {2'b00, op_i[0]};
               if (mem_y) uop_o.mode = AM_HLIND;
               else       uop_o.mode = AM_REG;
               uop_o.tim = tim_bump(TM_SHORT, mem_y);
            end
            3'd6: begin
               uop_o.cls  = CL_LD8;
               uop_o.dst  = ysel;
               uop_o.imm  = 2'd1;
               uop_o.mode = AM_IMM;
               uop_o.tim  = tim_bump(TM_MID, mem_y);
            end
            default: hit_o = 1'b0;
         endcase
      end else begin
         hit_o = 1'b0;
      end
   end

endmodule

// File: rtl/opdec_alu.sv
module opdec_alu
   import opdec_pkg::*;
(
   input  logic [7:0] op_i,
   output uop_t       uop_o,
   output logic       hit_o
);

   logic reg_form;
   logic imm_form;
   logic mem_src;

   assign reg_form = (op_i[7:6] == 2'b10);
   assign imm_form = (op_i[7:6] == 2'b11) && (op_i[2:0] == SLOT_MEM);
   assign mem_src  = (op_i[2:0] == SLOT_MEM);
   assign hit_o    = reg_form || imm_form;

   always_comb begin
      uop_o = uop_blank();
      if (hit_o) begin
         uop_o.cls = CL_ALU;
         uop_o.fn  = op_i[5:3];
         uop_o.dst = SLOT_ACC;
         if (imm_form) begin
            uop_o.imm  = 2'd1;
            uop_o.mode = AM_IMM;
            uop_o.tim  = TM_MID;
         end else begin
            uop_o.src = op_i[2:0];
            if (mem_src) uop_o.mode = AM_HLIND;
            else         uop_o.mode = AM_REG;
            uop_o.tim = tim_bump(TM_SHORT, mem_src);
         end
      end
   end

endmodule

// File: rtl/opdec_q3.sv
module opdec_q3
   import opdec_pkg::*;
#(
   parameter int VEC_SHIFT = 3
) (
   input  logic [7:0] op_i,
   output uop_t       uop_o,
   output logic       hit_o
);

   logic [2:0] zsel;
   logic       load_dir;

   assign zsel     = op_i[2:0];
   assign load_dir = op_i[4];

   always_comb begin
      uop_o = uop_blank();
      hit_o = 1'b1;
      if (op_i[7:6] != 2'b11) begin
         hit_o = 1'b0;
      end else begin
         case (zsel)
            3'd0, 3'd2: begin
               if (op_i[5] && !op_i[3]) begin
                  uop_o.cls = CL_LD8;
                  if (load_dir) uop_o.dst = SLOT_ACC;
                  else          uop_o.src = SLOT_ACC;
                  if (zsel == 3'd0) begin
                     uop_o.imm  = 2'd1;
                     uop_o.mode = AM_HIGH_IMM;
                     uop_o.tim  = TM_LONG;
                  end else begin
                     uop_o.mode = AM_HIGH_C;
                     uop_o.tim  = TM_MID;
                  end
               end else begin
                  hit_o = 1'b0;
               end
            end
            3'd1, 3'd5: begin
               if (!op_i[3]) begin
                  if (zsel == 3'd1) uop_o.cls = CL_POP;
                  else              uop_o.cls = CL_PUSH;
                  uop_o.pair    = op_i[5:4];
                  uop_o.pair_af = (op_i[5:4] == 2'd3);
                  uop_o.mode    = AM_STACK;
                  uop_o.tim     = TM_LONG;
               end else if (op_i == 8'hC9) begin
                  uop_o.cls  = CL_RET;
                  uop_o.mode = AM_STACK;
                  uop_o.tim  = TM_LONG;
               end else if (op_i == 8'hCD) begin
                  uop_o.cls  = CL_CALL;
                  uop_o.imm  = 2'd2;
                  uop_o.mode = AM_IMM;
                  uop_o.tim  = TM_LONG;
               end else begin
                  hit_o = 1'b0;
               end
            end
            3'd3: begin
               if (op_i == 8'hC3) begin
                  uop_o.cls  = CL_JUMP;
                  uop_o.imm  = 2'd2;
                  uop_o.mode = AM_IMM;
                  uop_o.tim  = TM_LONG;
               end else if (op_i == 8'hCB) begin
                  uop_o.cls    = CL_CTRL;
                  uop_o.fn     = 3'd3;
                  uop_o.prefix = 1'b1;
               end else begin
                  hit_o = 1'b0;
               end
            end
            3'd7: begin
               uop_o.cls  = CL_RST;
               uop_o.vec  = 8'(op_i[5:3]) << VEC_SHIFT;
               uop_o.mode = AM_STACK;
               uop_o.tim  = TM_LONG;
            end
            default: hit_o = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/byte_op_decoder.sv
module byte_op_decoder
   import opdec_pkg::*;
#(
   parameter int VEC_STEP  = 8,
   parameter bit HOLD_DESC = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       op_valid_i,
   input  logic [7:0] opcode_i,
   output logic       desc_valid_o,
   output logic [3:0] op_class_o,
   output logic [2:0] dst_o,
   output logic [2:0] src_o,
   output logic [1:0] pair_o,
   output logic [2:0] fn_o,
   output logic [1:0] imm_cnt_o,
   output logic [2:0] addr_mode_o,
   output logic [1:0] timing_o,
   output logic [7:0] rst_vec_o,
   output logic       prefix_o,
   output logic       pair_af_o,
   output logic       illegal_o
);

   localparam int VEC_SHIFT = $clog2(VEC_STEP);

   generate
      if ((VEC_STEP < 1) || (VEC_STEP > 32) || ((VEC_STEP & (VEC_STEP - 1)) != 0)) begin : g_bad_step
         $error("byte_op_decoder: VEC_STEP must be a power of two from 1 to 32");
      end
   endgenerate

   uop_t uop_lo, uop_alu, uop_hi, uop_d, uop_q, uop_idle;
   logic hit_lo, hit_alu, hit_hi, illegal_d, illegal_q, vld_q;

   opdec_q01 u_q01 (
      .op_i  (opcode_i),
      .uop_o (uop_lo),
      .hit_o (hit_lo)
   );

   opdec_alu u_alu (
      .op_i  (opcode_i),
      .uop_o (uop_alu),
      .hit_o (hit_alu)
   );

   opdec_q3 #(.VEC_SHIFT(VEC_SHIFT)) u_q3 (
      .op_i  (opcode_i),
      .uop_o (uop_hi),
      .hit_o (hit_hi)
   );

   always_comb begin
      illegal_d = 1'b0;
      if (hit_alu)     uop_d = uop_alu;
      else if (hit_lo) uop_d = uop_lo;
      else if (hit_hi) uop_d = uop_hi;
      else begin
         uop_d     = uop_blank();
         illegal_d = 1'b1;
      end
   end

   generate
      if (HOLD_DESC) begin : g_hold
         assign uop_idle = uop_q;
      end else begin : g_clear
         assign uop_idle = uop_blank();
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q     <= 1'b0;
         uop_q     <= uop_blank();
         illegal_q <= 1'b0;
      end else begin
         vld_q <= op_valid_i;
         if (op_valid_i) begin
            uop_q     <= uop_d;
            illegal_q <= illegal_d;
         end else begin
            uop_q     <= uop_idle;
            illegal_q <= HOLD_DESC ? illegal_q : 1'b0;
         end
      end
   end

   assign desc_valid_o = vld_q;
   assign op_class_o   = uop_q.cls;
   assign dst_o        = uop_q.dst;
   assign src_o        = uop_q.src;
   assign pair_o       = uop_q.pair;
   assign fn_o         = uop_q.fn;
   assign imm_cnt_o    = uop_q.imm;
   assign addr_mode_o  = uop_q.mode;
   assign timing_o     = uop_q.tim;
   assign rst_vec_o    = uop_q.vec;
   assign prefix_o     = uop_q.prefix;
   assign pair_af_o    = uop_q.pair_af;
   assign illegal_o    = illegal_q;

endmodule

// File: rtl/opdec_chk.sv
module opdec_chk #(
   parameter int VEC_STEP  = 8,
   parameter bit HOLD_DESC = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       op_valid_i,
   input logic [7:0] opcode_i,
   input logic       desc_valid_o,
   input logic [3:0] op_class_o,
   input logic [2:0] dst_o,
   input logic [2:0] src_o,
   input logic [1:0] pair_o,
   input logic [2:0] fn_o,
   input logic [1:0] imm_cnt_o,
   input logic [2:0] addr_mode_o,
   input logic [1:0] timing_o,
   input logic [7:0] rst_vec_o,
   input logic       prefix_o,
   input logic       pair_af_o,
   input logic       illegal_o
);

   localparam int VEC_SHIFT = $clog2(VEC_STEP);

   logic [32:0] desc_bus;
   assign desc_bus = {op_class_o, dst_o, src_o, pair_o, fn_o, imm_cnt_o, addr_mode_o,
                      timing_o, rst_vec_o, prefix_o, pair_af_o, illegal_o};

   AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid_i |=> desc_valid_o); // R1

   AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid_i |=> !desc_valid_o); // R1

   generate
      if (HOLD_DESC) begin : g_hold_chk
         AST_DESC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            !op_valid_i |=> $stable(desc_bus)); // R2
      end
   endgenerate

   AST_SLOT_MEM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && (opcode_i[7:6] == 2'b01) && (opcode_i != 8'h76) &&
       ((opcode_i[5:3] == 3'd6) || (opcode_i[2:0] == 3'd6)))
      |=> (timing_o == 2'd1) && (addr_mode_o == 3'd2)); // R3

   AST_ALU_TO_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && (opcode_i[7:6] == 2'b10))
      |=> (op_class_o == 4'd3) && (dst_o == 3'd7) && (fn_o == $past(opcode_i[5:3]))); // R4

   AST_STACK_AF: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && (opcode_i[7:6] == 2'b11) && (opcode_i[3:0] == 4'h5))
      |=> (pair_af_o == (pair_o == 2'd3)) && (op_class_o == 4'd9)); // R8

   AST_RST_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && (opcode_i[7:6] == 2'b11) && (opcode_i[2:0] == 3'd7))
      |=> rst_vec_o == (8'($past(opcode_i[5:3])) << VEC_SHIFT)); // R9

   AST_PREFIX_IS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
      prefix_o |-> (op_class_o == 4'd11) && (fn_o == 3'd3)); // R12

   AST_ILLEGAL_IS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_valid_o && illegal_o) |-> (op_class_o == 4'd0) && (imm_cnt_o == 2'd0)); // R13

endmodule

bind byte_op_decoder opdec_chk #(.VEC_STEP(VEC_STEP), .HOLD_DESC(HOLD_DESC)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .op_valid_i   (op_valid_i),
   .opcode_i     (opcode_i),
   .desc_valid_o (desc_valid_o),
   .op_class_o   (op_class_o),
   .dst_o        (dst_o),
   .src_o        (src_o),
   .pair_o       (pair_o),
   .fn_o         (fn_o),
   .imm_cnt_o    (imm_cnt_o),
   .addr_mode_o  (addr_mode_o),
   .timing_o     (timing_o),
   .rst_vec_o    (rst_vec_o),
   .prefix_o     (prefix_o),
   .pair_af_o    (pair_af_o),
   .illegal_o    (illegal_o)
);

// File: tb/byte_op_decoder_tb_top.sv
`timescale 1ns/1ps
module byte_op_decoder_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid_i = 1'b0;
   logic [7:0] opcode_i = 8'h00;
   logic       desc_valid_o;
   logic [3:0] op_class_o;
   logic [2:0] dst_o, src_o, fn_o, addr_mode_o;
   logic [1:0] pair_o, imm_cnt_o, timing_o;
   logic [7:0] rst_vec_o;
   logic       prefix_o, pair_af_o, illegal_o;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   byte_op_decoder dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .op_valid_i   (op_valid_i),
      .opcode_i     (opcode_i),
      .desc_valid_o (desc_valid_o),
      .op_class_o   (op_class_o),
      .dst_o        (dst_o),
      .src_o        (src_o),
      .pair_o       (pair_o),
      .fn_o         (fn_o),
      .imm_cnt_o    (imm_cnt_o),
      .addr_mode_o  (addr_mode_o),
      .timing_o     (timing_o),
      .rst_vec_o    (rst_vec_o),
      .prefix_o     (prefix_o),
      .pair_af_o    (pair_af_o),
      .illegal_o    (illegal_o)
   );

   function automatic logic [33:0] observed();
      return {desc_valid_o, op_class_o, dst_o, src_o, pair_o, fn_o, imm_cnt_o,
              addr_mode_o, timing_o, rst_vec_o, prefix_o, illegal_o, pair_af_o};
   endfunction

   // Expected descriptor computed from the requirement text, field by field.
   function automatic void expect_for(input int o, output logic [33:0] e, output string tag);
      int c, d, s, p, f, n, m, t, v, pf, il, af;
      int q, x, z, y;
      bit six;
      c = 0; d = 0; s = 0; p = 0; f = 0; n = 0; m = 0; t = 0; v = 0; pf = 0; il = 0; af = 0;
      q = o / 64; x = (o / 8) % 8; z = o % 8; y = (o / 16) % 4;
      tag = "R13";
      if (o == 0) tag = "R12";
      else if (o == 16)  begin c = 11; f = 2; tag = "R12"; end
      else if (o == 203) begin c = 11; f = 3; pf = 1; tag = "R12"; end
      else if (o == 118) begin c = 11; f = 1; tag = "R12"; end
      else if (q == 1) begin
         six = (x == 6) || (z == 6);
         c = 1; d = x; s = z; m = six ? 2 : 1; t = six ? 1 : 0; tag = "R3";
      end else if (q == 2) begin
         c = 3; f = x; d = 7; s = z; m = (z == 6) ? 2 : 1; t = (z == 6) ? 1 : 0; tag = "R4";
      end else if (q == 3 && z == 6) begin
         c = 3; f = x; d = 7; n = 1; m = 3; t = 1; tag = "R5";
      end else if (q == 0 && z == 6) begin
         c = 1; d = x; n = 1; m = 3; t = (x == 6) ? 2 : 1; tag = "R6";
      end else if (q == 0 && (z == 4 || z == 5)) begin
         c = 4; d = x; f = z - 4; m = (x == 6) ? 2 : 1; t = (x == 6) ? 1 : 0; tag = "R6";
      end else if (q == 0 && o % 16 == 1) begin
         c = 2; p = y; n = 2; m = 3; t = 2; tag = "R7";
      end else if (q == 0 && z == 3) begin
         c = 4; p = y; f = (o / 8) % 2; m = 1; t = 1; tag = "R7";
      end else if (q == 0 && o % 16 == 9) begin
         c = 12; p = y; m = 1; t = 1; tag = "R7";
      end else if (o == 24 || o == 32 || o == 40 || o == 48 || o == 56) begin
         c = 5; n = 1; m = 6; t = 2; tag = "R11";
      end else if (o == 195) begin c = 5; n = 2; m = 3; t = 2; tag = "R11"; end
      else if (o == 205) begin c = 6; n = 2; m = 3; t = 2; tag = "R11"; end
      else if (o == 201) begin c = 7; m = 7; t = 2; tag = "R11"; end
      else if (q == 3 && z == 7) begin c = 8; v = x * 8; m = 7; t = 2; tag = "R9"; end
      else if (q == 3 && o % 16 == 5) begin
         c = 9; p = y; m = 7; t = 2; af = (y == 3); tag = "R8";
      end else if (q == 3 && o % 16 == 1) begin
         c = 10; p = y; m = 7; t = 2; af = (y == 3); tag = "R8";
      end else if (o == 224) begin c = 1; s = 7; n = 1; m = 4; t = 2; tag = "R10"; end
      else if (o == 240) begin c = 1; d = 7; n = 1; m = 4; t = 2; tag = "R10"; end
      else if (o == 226) begin c = 1; s = 7; m = 5; t = 1; tag = "R10"; end
      else if (o == 242) begin c = 1; d = 7; m = 5; t = 1; tag = "R10"; end
      else il = 1;
      e = {1'b1, 4'(c), 3'(d), 3'(s), 2'(p), 3'(f), 2'(n), 3'(m), 2'(t), 8'(v),
           1'(pf), 1'(il), 1'(af)};
   endfunction

   task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp,
                        input int op);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s op=%02h actual=%09h expected=%09h", tag, op, act, exp);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [33:0] exp, last;
      string tag;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", observed(), 34'h0, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // exhaustive back-to-back sweep
      for (int op = 0; op < 256; op++) begin
         op_valid_i = 1'b1;
         opcode_i   = 8'(op);
         @(negedge clk);
         expect_for(op, exp, tag);
         check(tag, observed(), exp, op);
      end
      // re-issue a push of the flags pair, then leave gaps
      opcode_i = 8'hF5;
      @(negedge clk);
      expect_for(245, last, tag);
      check("R8", observed(), last, 245);
      op_valid_i = 1'b0;
      opcode_i   = 8'h3C;
      @(negedge clk);
      // R1: valid drops, R2: fields held
      check("R1", {33'h0, desc_valid_o}, 34'h0, 60);
      check("R2", {1'b1, observed()[32:0]}, last, 60);
      opcode_i = 8'hFF;
      @(negedge clk);
      check("R2", {1'b1, observed()[32:0]}, last, 255);
      // a fresh strobe after the gap decodes normally
      op_valid_i = 1'b1;
      opcode_i   = 8'h36;
      @(negedge clk);
      expect_for(54, exp, tag);
      check("R6", observed(), exp, 54);
      op_valid_i = 1'b0;
      @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule